// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block decides, cycle by cycle, whether a quasi-resonant flyback controller may switch its power transistor at light load. Comparators outside the block compare the feedback voltage against a low and a high burst level (about 1.2 V and 1.25 V) and against the level that matches the minimum peak current. Their outputs arrive as synchronous flags. From these flags the block produces a switching enable, a request to clamp the peak current at its minimum value, and a low-power indication for the supply.

Switching stops when feedback drops under the low level. It restarts only once feedback climbs over the high level, so the gap between the two levels gives hysteresis. If feedback stays low long enough (640 µs by default), the block enters a deep sleep tier and raises the low-power indication. Waking from that tier takes a fixed, counted delay (25 µs by default) to re-establish normal supply before switching is enabled again. While switching runs with feedback under the minimum-peak level, every cycle is clamped to the minimum peak current.

Top module: `lpm_burst_ctrl`

## Requirements
- R1: After synchronous reset, sw_en is 1, deep_burst is 0 and imin_clamp is 0.
- R2: While switching, a clock edge that samples fb_low=1 with fb_high=0 makes sw_en 0 right after that edge.
- R3: With switching stopped outside deep burst, sw_en stays 0 while neither flag is set and returns to 1 right after the edge that samples fb_high=1.
- R4: When both flags are 1 at the same edge, fb_high wins: a running block keeps sw_en at 1.
- R5: deep_burst rises right after the edge that completes ENTRY_CYCLES consecutive samples of fb_low=1 taken while switching is already off. The sample that stopped switching is not counted. ENTRY_CYCLES = ENTRY_US*CLK_MHZ.
- R6: While switching is off and deep_burst is 0, any edge that samples fb_low=0 restarts the R5 count from zero.
- R7: In deep burst, deep_burst stays 1 until an edge samples fb_high=1. deep_burst then drops right after that edge, sw_en stays 0 for WAKE_CYCLES edges in all, and sw_en rises right after edge WAKE_CYCLES, counting the fb_high edge as edge 0. WAKE_CYCLES = WAKE_US*CLK_MHZ.
- R8: During the wake delay the feedback flags are ignored: fb_low=1 neither shortens nor extends the delay and does not raise deep_burst.
- R9: imin_clamp equals fb_imin sampled at the previous edge, ANDed with the current sw_en.
- R10: sw_en and deep_burst are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_low | input | 1 | Feedback is under the low burst level |
| fb_high | input | 1 | Feedback is over the high burst level |
| fb_imin | input | 1 | Feedback is under the minimum-peak-current level |
| sw_en | output | 1 | Switching permitted |
| deep_burst | output | 1 | Deep sleep tier active (reduced supply current) |
| imin_clamp | output | 1 | Clamp the peak current at its minimum |

## Verification
The hysteresis is tested by moving feedback from low into the band between the levels and then high. Only the high crossing may restart switching, which separates a hysteretic design from one that follows a single threshold. Deep-burst entry is tested both with an uninterrupted low run and with a run broken by one in-band sample one cycle before expiry. This separates an entry timer that restarts from one that merely pauses. The wake path is tested once with quiet feedback and once with the low flag held throughout, which shows whether the counted delay is truly immune to feedback. Simultaneous flags and the clamp path round out the priority and gating cases.

// File: rtl/lpm_pkg.sv
// Shared types for the light-load burst mode controller.
package lpm_pkg;
    // Operating tiers of the controller.
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,   // switching permitted
        ST_HOLD = 2'd1,   // burst pause, switching off, entry timer running
        ST_DEEP = 2'd2,   // deep sleep tier, reduced supply
        ST_WAKE = 2'd3    // counted wake delay before switching resumes
    } lpm_state_e;
endpackage

// File: rtl/lpm_interval_timer.sv
// Saturating interval counter.
// Counts edges while run is high and clears whenever clr is high (clr wins).
// expired is high once LIMIT-1 is reached, so with run held, expiry is
// seen after LIMIT-1 counting edges. Assumes LIMIT >= 1.
module lpm_interval_timer #(
    parameter int LIMIT = 4,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    logic [W-1:0] cnt;

    // Counter update: clear, count up, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (run && (cnt != W'(LIMIT - 1))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry flag.
    always_comb begin
        expired = (cnt == W'(LIMIT - 1));
    end
endmodule

// File: rtl/lpm_mode_fsm.sv
// Tier sequencer for the burst mode controller.
// Assumes flags are synchronous to clk. fb_high wins over fb_low.
// Timer expiries come from external interval timers.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fb_low,
    input  logic       fb_high,
    input  logic       entry_exp,
    input  logic       wake_exp,
    output lpm_state_e state,
    output logic       sw_en,
    output logic       deep_burst
);
    lpm_state_e state_nx;
    logic       low_only;

    // Low request counts only when the high flag is absent.
    always_comb begin
        low_only = fb_low && !fb_high;
    end

    // Next-tier decision.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (low_only) state_nx = ST_HOLD;
            ST_HOLD: begin
                if (fb_high)                    state_nx = ST_RUN;
                else if (fb_low && entry_exp)   state_nx = ST_DEEP;
            end
            ST_DEEP: if (fb_high)  state_nx = ST_WAKE;
            ST_WAKE: if (wake_exp) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    // Tier register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Output decode from the registered tier.
    always_comb begin
        sw_en      = (state == ST_RUN);
        deep_burst = (state == ST_DEEP);
    end
endmodule

// File: rtl/lpm_burst_ctrl.sv
// Light-load burst mode controller (top).
// Gates switching with hysteresis on two feedback flags, enters a deep
// sleep tier after a sustained low interval and leaves it through a
// counted wake delay. Requests the minimum peak current while switching
// with feedback under the minimum-peak level.
// Assumes all flags are already synchronous to clk.
module lpm_burst_ctrl
    import lpm_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int ENTRY_US = 640,
    parameter int WAKE_US  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_low,
    input  logic fb_high,
    input  logic fb_imin,
    output logic sw_en,
    output logic deep_burst,
    output logic imin_clamp
);
    localparam int ENTRY_CYCLES = ENTRY_US * CLK_MHZ;
    localparam int WAKE_CYCLES  = WAKE_US * CLK_MHZ;

    lpm_state_e state;
    logic entry_run, entry_exp;
    logic wake_run, wake_exp;
    logic imin_q;

    // Timer controls: entry counts low samples in the pause tier only.
    always_comb begin
        entry_run = (state == ST_HOLD) && fb_low && !fb_high;
        wake_run  = (state == ST_WAKE);
    end

    lpm_interval_timer #(.LIMIT(ENTRY_CYCLES)) u_entry_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!entry_run),
        .run     (entry_run),
        .expired (entry_exp)
    );

    lpm_interval_timer #(.LIMIT(WAKE_CYCLES)) u_wake_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!wake_run),
        .run     (wake_run),
        .expired (wake_exp)
    );

    lpm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fb_low     (fb_low),
        .fb_high    (fb_high),
        .entry_exp  (entry_exp),
        .wake_exp   (wake_exp),
        .state      (state),
        .sw_en      (sw_en),
        .deep_burst (deep_burst)
    );

    // Register the minimum-peak flag.
    always_ff @(posedge clk) begin
        if (!rst_n) imin_q <= 1'b0;
        else        imin_q <= fb_imin;
    end

    // Clamp request only matters while switching.
    always_comb begin
        imin_clamp = imin_q && sw_en;
    end
endmodule

// File: rtl/lpm_burst_ctrl_chk.sv
// Property checker for lpm_burst_ctrl, attached by bind.
// Uses counters for the long entry and wake windows.
module lpm_burst_ctrl_chk #(
    parameter int CLK_MHZ  = 125,
    parameter int ENTRY_US = 640,
    parameter int WAKE_US  = 25
) (
    input logic clk,
    input logic rst_n,
    input logic fb_low,
    input logic fb_high,
    input logic fb_imin,
    input logic sw_en,
    input logic deep_burst,
    input logic imin_clamp
);
    localparam int ENTRY_CYCLES = ENTRY_US * CLK_MHZ;
    localparam int WAKE_CYCLES  = WAKE_US * CLK_MHZ;

    int   low_run;
    int   wake_cnt;
    logic waking;
    logic deep_prev;

    // Consecutive low samples while paused outside deep burst.
    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= 0;
        else if (fb_low && !fb_high && !sw_en && !deep_burst) begin
            if (low_run < ENTRY_CYCLES + 1) low_run <= low_run + 1;
        end else low_run <= 0;
    end

    // Edges elapsed since deep burst ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deep_prev <= 1'b0;
            waking    <= 1'b0;
            wake_cnt  <= 0;
        end else begin
            deep_prev <= deep_burst;
            if (deep_prev && !deep_burst) begin
                waking   <= 1'b1;
                wake_cnt <= 1;
            end else if (sw_en) begin
                waking <= 1'b0;
            end else if (waking && wake_cnt < WAKE_CYCLES + 1) begin
                wake_cnt <= wake_cnt + 1;
            end
        end
    end

    a_r2_low_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && fb_low && !fb_high) |=> !sw_en);

    a_r4_high_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && fb_high) |=> sw_en);

    a_r5_entry_span: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deep_burst) |-> (low_run == ENTRY_CYCLES));

    a_r7_deep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_burst && !fb_high) |=> deep_burst);

    a_r7_wake_span: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sw_en) && waking) |-> (wake_cnt == WAKE_CYCLES));

    a_r9_clamp_gated: assert property (@(posedge clk) disable iff (!rst_n)
        imin_clamp |-> (sw_en && $past(fb_imin)));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en && deep_burst));
endmodule

bind lpm_burst_ctrl lpm_burst_ctrl_chk #(
    .CLK_MHZ (CLK_MHZ),
    .ENTRY_US(ENTRY_US),
    .WAKE_US (WAKE_US)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fb_low     (fb_low),
    .fb_high    (fb_high),
    .fb_imin    (fb_imin),
    .sw_en      (sw_en),
    .deep_burst (deep_burst),
    .imin_clamp (imin_clamp)
);

// File: tb/tb_lpm_burst_ctrl.sv
// Directed bench for lpm_burst_ctrl with shortened timing windows.
module tb_lpm_burst_ctrl;
    localparam int CLK_MHZ = 1;
    localparam int ENTRY   = 20;
    localparam int WAKE    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_low = 1'b0, fb_high = 1'b0, fb_imin = 1'b0;
    logic sw_en, deep_burst, imin_clamp;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    lpm_burst_ctrl #(.CLK_MHZ(CLK_MHZ), .ENTRY_US(ENTRY), .WAKE_US(WAKE)) dut (
        .clk(clk), .rst_n(rst_n), .fb_low(fb_low), .fb_high(fb_high),
        .fb_imin(fb_imin), .sw_en(sw_en), .deep_burst(deep_burst),
        .imin_clamp(imin_clamp)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_fb(input logic lo, input logic hi);
        fb_low  = lo;
        fb_high = hi;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; set_fb(0, 0); fb_imin = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R1 sw_en", sw_en, 1);
        chk("R1 deep_burst", deep_burst, 0);
        chk("R1 imin_clamp", imin_clamp, 0);
    endtask

    task automatic t_hysteresis();
        set_fb(1, 0); tick();
        chk("R2 stop on low", sw_en, 0);
        set_fb(0, 0); tick(3);
        chk("R3 band keeps off", sw_en, 0);
        set_fb(0, 1); tick();
        chk("R3 resume on high", sw_en, 1);
        set_fb(0, 0); tick();
        chk("R3 band keeps running", sw_en, 1);
    endtask

    task automatic t_priority();
        set_fb(1, 1); tick();
        chk("R4 both flags", sw_en, 1);
        set_fb(0, 0); tick();
    endtask

    task automatic t_clamp();
        fb_imin = 1'b1; tick();
        chk("R9 clamp while running", imin_clamp, 1);
        set_fb(1, 0); tick();
        chk("R9 clamp off when paused", imin_clamp, 0);
        set_fb(0, 1); tick();
        chk("R9 clamp back", imin_clamp, 1);
        set_fb(0, 0); fb_imin = 1'b0; tick();
        chk("R9 clamp released", imin_clamp, 0);
    endtask

    task automatic t_deep_and_wake();
        set_fb(1, 0); tick();
        chk("R2 paused", sw_en, 0);
        tick(ENTRY - 1);
        chk("R5 not yet deep", deep_burst, 0);
        tick();
        chk("R5 deep entered", deep_burst, 1);
        chk("R10 no switching in deep", sw_en, 0);
        set_fb(0, 0); tick(3);
        chk("R7 deep holds in band", deep_burst, 1);
        set_fb(0, 1); tick();
        chk("R7 deep released", deep_burst, 0);
        chk("R7 still off at wake start", sw_en, 0);
        set_fb(0, 0); tick(WAKE - 1);
        chk("R7 off through wake", sw_en, 0);
        tick();
        chk("R7 resumes after wake", sw_en, 1);
    endtask

    task automatic t_restart_and_ignore();
        set_fb(1, 0); tick();
        tick(ENTRY - 2);
        set_fb(0, 0); tick();
        set_fb(1, 0); tick(ENTRY - 1);
        chk("R6 restart delays entry", deep_burst, 0);
        tick();
        chk("R6 entry after full span", deep_burst, 1);
        set_fb(0, 1); tick();
        set_fb(1, 0); tick(WAKE - 1);
        chk("R8 wake off with low", sw_en, 0);
        chk("R8 no deep during wake", deep_burst, 0);
        tick();
        chk("R8 wake length unchanged", sw_en, 1);
        tick();
        chk("R2 low stops after wake", sw_en, 0);
        set_fb(0, 1); tick();
        set_fb(0, 0);
    endtask

    initial begin
        t_reset();
        t_hysteresis();
        t_priority();
        t_clamp();
        t_deep_and_wake();
        t_restart_and_ignore();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule